// File: doc/BRIEF.md
# Reorder Buffer with Early Branch Recovery

This block is the in-order commit stage of a small out-of-order core. Instructions enter at the tail in program order and each receives a slot tag. Execution units later report completion against that tag. A report can mark the instruction as faulting, or, for a branch, as mispredicted together with the corrected target. Completed instructions leave from the head, at most one per cycle, and every retiring store raises a one-cycle pulse that a downstream store buffer counts and drains.

Branch recovery does not wait for retirement. When a mispredict is reported, every slot younger than the branch is released at once and fetch is steered to the corrected target in that same cycle, even while older instructions are still executing. A later mispredict on an older branch rewinds further and discards the earlier recovery path as well. Faults are held back until the faulting instruction is the oldest one, and only then flush the buffer and raise the exception. An external interrupt is accepted at once, with no grace cycles. It discards all unretired work and reports a resume address, but if the head is a finished mispredicted branch it lets that branch retire in the same cycle and resumes at the branch's corrected target.

The program counter counts instructions, so the instruction after address `p` is at `p + 1`. When the buffer is empty, the next fetch address is the address after the last accepted allocation, or the most recent redirect, exception or resume address if that came later.

Top module: `rob_core`

## Requirements
- R1: With 2^IDX_W entries occupied, `allocReady` is low, and an allocation offered while full is dropped: it never retires.
- R2: Entries retire strictly in allocation order, at most one per cycle, and only once the head entry has completed. A completed entry behind an incomplete head waits.
- R3: A mispredict completion raises `redirectValid` with `redirectPc` equal to the reported target in that same cycle. Every younger entry is squashed, and the next allocation receives the tag just after the branch.
- R4: A mispredict on an older branch, reported after a younger branch's recovery, squashes everything younger than the older branch, including the recovered path.
- R5: A faulting completion has no visible effect until that entry is the oldest. Then `excValid` is high with `excPc` equal to its address, the entry does not retire, and every unretired entry is discarded.
- R6: An accepted interrupt (`irqTaken`) discards all unretired entries. `resumePc` is the oldest unretired address, or the next fetch address when the buffer is empty.
- R7: If the head is a completed mispredicted branch when an interrupt is accepted, that branch retires in the same cycle and `resumePc` is its corrected target.
- R8: `storeRetire` pulses once for each retired store, and a later flush does not withdraw a pulse already given.
- R9: Within one cycle, a head exception beats an interrupt, and an interrupt beats a mispredict completion. Allocation is refused in any cycle with an exception, an interrupt or a mispredict.
- R10: After reset the buffer is empty, `allocReady` is high, and no retire, exception, redirect or interrupt output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | Offer of a new instruction |
| allocPc | input | PC_W | Address of the offered instruction |
| allocIsBranch | input | 1 | Offered instruction is a branch |
| allocIsStore | input | 1 | Offered instruction is a store |
| allocReady | output | 1 | Allocation accepted this cycle if offered |
| allocTag | output | IDX_W | Slot tag given to the offered instruction |
| cplValid | input | 1 | Completion report |
| cplTag | input | IDX_W | Slot tag of the completing instruction |
| cplFault | input | 1 | Completing instruction faulted |
| cplMispredict | input | 1 | Completing branch was mispredicted |
| cplTarget | input | PC_W | Corrected target of a mispredicted branch |
| irqReq | input | 1 | External interrupt request |
| retireValid | output | 1 | Head entry retires this cycle |
| retirePc | output | PC_W | Address of the retiring entry |
| storeRetire | output | 1 | Retiring entry is a store |
| redirectValid | output | 1 | Fetch redirect after a mispredict |
| redirectPc | output | PC_W | Redirect target |
| excValid | output | 1 | Exception taken at the head |
| excPc | output | PC_W | Address of the faulting instruction |
| irqTaken | output | 1 | Interrupt accepted this cycle |
| resumePc | output | PC_W | Address at which to resume after the interrupt |

## Verification
The stimulus makes several events fall in one cycle. In one case the interrupt arrives exactly in the first cycle that a finished mispredicted branch sits at the head. The bench expects that branch in the retire log and its corrected target as the resume address. In other cases an interrupt meets a waiting head fault, and an interrupt arrives together with a mispredict report and a new allocation. The bench judges each from the event counters and the retire log it keeps at the ports: exactly one winner, the loser leaves no trace, and the refused allocation never retires.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Write strobes from control to the entry storage
  typedef struct packed {
    logic allocWe;
    logic cplWe;
  } robStrobe_t;
endpackage

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  robStrobe_t       strobe,
  input  logic [IDX_W-1:0] allocIdx,
  input  logic [PC_W-1:0]  allocPc,
  input  logic             allocIsBranch,
  input  logic             allocIsStore,
  input  logic [IDX_W-1:0] cplIdx,
  input  logic             cplFault,
  input  logic             cplMisp,
  input  logic [PC_W-1:0]  cplTarget,
  input  logic [IDX_W-1:0] headIdx,
  output logic             headDone,
  output logic             headFault,
  output logic             headMisp,
  output logic             headIsStore,
  output logic [PC_W-1:0]  headPc,
  output logic [PC_W-1:0]  headTarget
);
  localparam int DEPTH = 1 << IDX_W;

  logic [PC_W-1:0] pcMem [DEPTH];
  logic [PC_W-1:0] tgtMem [DEPTH];
  logic [DEPTH-1:0] doneV, faultV, mispV, brV, stV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneV  <= '0;
      faultV <= '0;
      mispV  <= '0;
      brV    <= '0;
      stV    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pcMem[i]  <= '0;
        tgtMem[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.allocWe && allocIdx == IDX_W'(i)) begin
          pcMem[i]  <= allocPc;
          brV[i]    <= allocIsBranch;
          stV[i]    <= allocIsStore;
          doneV[i]  <= 1'b0;
          faultV[i] <= 1'b0;
          mispV[i]  <= 1'b0;
        end else if (strobe.cplWe && cplIdx == IDX_W'(i)) begin
          doneV[i]  <= 1'b1;
          faultV[i] <= cplFault;
          mispV[i]  <= cplMisp & brV[i] & ~cplFault;
          tgtMem[i] <= cplTarget;
        end
      end
    end
  end

  assign headDone    = doneV[headIdx];
  assign headFault   = faultV[headIdx];
  assign headMisp    = mispV[headIdx];
  assign headIsStore = stV[headIdx];
  assign headPc      = pcMem[headIdx];
  assign headTarget  = tgtMem[headIdx];
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int PC_W     = 16,
  parameter int RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocValid,
  input  logic [PC_W-1:0]  allocPc,
  input  logic             cplValid,
  input  logic [IDX_W-1:0] cplTag,
  input  logic             cplFault,
  input  logic             cplMispredict,
  input  logic [PC_W-1:0]  cplTarget,
  input  logic             irqReq,
  input  logic             headDone,
  input  logic             headFault,
  input  logic             headMisp,
  input  logic             headIsStore,
  input  logic [PC_W-1:0]  headPc,
  input  logic [PC_W-1:0]  headTarget,
  output robStrobe_t       strobe,
  output logic [IDX_W-1:0] headIdx,
  output logic [IDX_W-1:0] tailIdx,
  output logic             allocReady,
  output logic             retireValid,
  output logic [PC_W-1:0]  retirePc,
  output logic             storeRetire,
  output logic             redirectValid,
  output logic [PC_W-1:0]  redirectPc,
  output logic             excValid,
  output logic [PC_W-1:0]  excPc,
  output logic             irqTaken,
  output logic [PC_W-1:0]  resumePc
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] headPtr, tailPtr, headNext, tailNext, count, squashTail;
  logic [PC_W-1:0]  nextFetch, fetchNext;
  logic [IDX_W-1:0] cplAge;
  logic empty, full, headReady, excTake, irqTake, irqRetire;
  logic cplLive, mispTake, flushing, allocFire;

  assign count   = tailPtr - headPtr;
  assign empty   = (count == '0);
  assign full    = (count == PTR_W'(DEPTH));
  assign headIdx = headPtr[IDX_W-1:0];
  assign tailIdx = tailPtr[IDX_W-1:0];

  // Event arbitration: head fault, then interrupt, then mispredict
  assign headReady = !empty && headDone;
  assign excTake   = headReady && headFault;
  assign irqTake   = irqReq && !excTake;
  assign irqRetire = irqTake && headReady && headMisp;
  assign cplAge    = cplTag - headIdx;
  assign cplLive   = cplValid && ({1'b0, cplAge} < count);
  assign mispTake  = cplLive && cplMispredict && !cplFault && !excTake && !irqTake;
  assign flushing  = excTake || irqTake || mispTake;
  assign allocReady = !full && !flushing;
  assign allocFire  = allocValid && allocReady;
  assign squashTail = headPtr + {1'b0, cplAge} + PTR_W'(1);

  assign strobe.allocWe = allocFire;
  assign strobe.cplWe   = cplLive && !excTake && !irqTake;

  assign retireValid   = (headReady && !headFault && !irqTake) || irqRetire;
  assign retirePc      = headPc;
  assign storeRetire   = retireValid && headIsStore;
  assign redirectValid = mispTake;
  assign redirectPc    = cplTarget;
  assign excValid      = excTake;
  assign excPc         = headPc;
  assign irqTaken      = irqTake;
  assign resumePc      = irqRetire ? headTarget : (empty ? nextFetch : headPc);

  always_comb begin
    headNext  = headPtr + PTR_W'(retireValid);
    tailNext  = tailPtr;
    fetchNext = nextFetch;
    if (excTake) begin
      tailNext  = headPtr;
      fetchNext = headPc;
    end else if (irqTake) begin
      tailNext  = headNext;
      fetchNext = resumePc;
    end else if (mispTake) begin
      tailNext  = squashTail;
      fetchNext = cplTarget;
    end else if (allocFire) begin
      tailNext  = tailPtr + PTR_W'(1);
      fetchNext = allocPc + PC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      nextFetch <= PC_W'(RESET_PC);
    end else begin
      headPtr   <= headNext;
      tailPtr   <= tailNext;
      nextFetch <= fetchNext;
    end
  end

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tailPtr - headPtr) <= PTR_W'(DEPTH));
  a_r3_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    redirectValid |=> ((tailPtr - headPtr) <= $past(tailPtr - headPtr)));
  a_r5_exc_empties: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |=> (tailPtr == headPtr));
  a_r6_irq_empties: assert property (@(posedge clk) disable iff (!rst_n)
    irqTaken |=> (tailPtr == headPtr));
  a_r9_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    excValid |-> (!irqTaken && !redirectValid && !retireValid));
  a_r9_irq_beats_misp: assert property (@(posedge clk) disable iff (!rst_n)
    irqTaken |-> !redirectValid);
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int PC_W     = 16,
  parameter int RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocValid,
  input  logic [PC_W-1:0]  allocPc,
  input  logic             allocIsBranch,
  input  logic             allocIsStore,
  output logic             allocReady,
  output logic [IDX_W-1:0] allocTag,
  input  logic             cplValid,
  input  logic [IDX_W-1:0] cplTag,
  input  logic             cplFault,
  input  logic             cplMispredict,
  input  logic [PC_W-1:0]  cplTarget,
  input  logic             irqReq,
  output logic             retireValid,
  output logic [PC_W-1:0]  retirePc,
  output logic             storeRetire,
  output logic             redirectValid,
  output logic [PC_W-1:0]  redirectPc,
  output logic             excValid,
  output logic [PC_W-1:0]  excPc,
  output logic             irqTaken,
  output logic [PC_W-1:0]  resumePc
);
  robStrobe_t       strobe;
  logic [IDX_W-1:0] headIdx;
  logic             headDone, headFault, headMisp, headIsStore;
  logic [PC_W-1:0]  headPc, headTarget;

  rob_ctrl #(.IDX_W(IDX_W), .PC_W(PC_W), .RESET_PC(RESET_PC)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocPc(allocPc),
    .cplValid(cplValid), .cplTag(cplTag), .cplFault(cplFault),
    .cplMispredict(cplMispredict), .cplTarget(cplTarget),
    .irqReq(irqReq),
    .headDone(headDone), .headFault(headFault), .headMisp(headMisp),
    .headIsStore(headIsStore), .headPc(headPc), .headTarget(headTarget),
    .strobe(strobe), .headIdx(headIdx), .tailIdx(allocTag),
    .allocReady(allocReady),
    .retireValid(retireValid), .retirePc(retirePc), .storeRetire(storeRetire),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .excValid(excValid), .excPc(excPc),
    .irqTaken(irqTaken), .resumePc(resumePc)
  );

  rob_store #(.IDX_W(IDX_W), .PC_W(PC_W)) u_store (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .allocIdx(allocTag), .allocPc(allocPc),
    .allocIsBranch(allocIsBranch), .allocIsStore(allocIsStore),
    .cplIdx(cplTag), .cplFault(cplFault), .cplMisp(cplMispredict),
    .cplTarget(cplTarget), .headIdx(headIdx),
    .headDone(headDone), .headFault(headFault), .headMisp(headMisp),
    .headIsStore(headIsStore), .headPc(headPc), .headTarget(headTarget)
  );
endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;
  localparam int IW = 3;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic allocValid = 1'b0, allocIsBranch = 1'b0, allocIsStore = 1'b0;
  logic [PW-1:0] allocPc = '0;
  logic allocReady;
  logic [IW-1:0] allocTag;
  logic cplValid = 1'b0, cplFault = 1'b0, cplMispredict = 1'b0;
  logic [IW-1:0] cplTag = '0;
  logic [PW-1:0] cplTarget = '0;
  logic irqReq = 1'b0;
  logic retireValid, storeRetire, redirectValid, excValid, irqTaken;
  logic [PW-1:0] retirePc, redirectPc, excPc, resumePc;

  rob_core #(.IDX_W(IW), .PC_W(PW), .RESET_PC(0)) u0 (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocPc(allocPc), .allocIsBranch(allocIsBranch),
    .allocIsStore(allocIsStore), .allocReady(allocReady), .allocTag(allocTag),
    .cplValid(cplValid), .cplTag(cplTag), .cplFault(cplFault),
    .cplMispredict(cplMispredict), .cplTarget(cplTarget), .irqReq(irqReq),
    .retireValid(retireValid), .retirePc(retirePc), .storeRetire(storeRetire),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .excValid(excValid), .excPc(excPc), .irqTaken(irqTaken), .resumePc(resumePc)
  );

  always #5 clk = ~clk;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [PW-1:0] retLog [64];
  int retN = 0, storeN = 0, excN = 0, irqN = 0, redirN = 0;
  logic [PW-1:0] lastExc = '0, lastResume = '0, lastRedir = '0;

  // Port monitor: samples 1 ns before each rising edge
  always begin
    @(negedge clk);
    #4;
    if (rst_n) begin
      if (retireValid) begin
        if (retN < 64) retLog[retN] = retirePc;
        retN++;
      end
      if (storeRetire) storeN++;
      if (excValid) begin excN++; lastExc = excPc; end
      if (irqTaken) begin irqN++; lastResume = resumePc; end
      if (redirectValid) begin redirN++; lastRedir = redirectPc; end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic allocOne(input int pc, input bit br, input bit st, output logic [IW-1:0] tag);
    allocValid = 1'b1; allocPc = PW'(pc); allocIsBranch = br; allocIsStore = st;
    #1 tag = allocTag;
    @(negedge clk);
    allocValid = 1'b0; allocIsBranch = 1'b0; allocIsStore = 1'b0;
  endtask

  task automatic cpl(input logic [IW-1:0] tag, input bit f, input bit m, input int tgt);
    cplValid = 1'b1; cplTag = tag; cplFault = f; cplMispredict = m; cplTarget = PW'(tgt);
    @(negedge clk);
    cplValid = 1'b0; cplFault = 1'b0; cplMispredict = 1'b0;
  endtask

  task automatic pulseIrq();
    irqReq = 1'b1;
    @(negedge clk);
    irqReq = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [IW-1:0] t [8];
    logic [IW-1:0] a0, a1, a2, a3, b0, b1, b2, c0, c1, d0, e0, e1, e2, g0, h0, i0, j1, k0, x;
    int base, sBase, eBase, iBase, rBase;

    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 allocReady", allocReady, 1);
    check("R10 quiet outputs", {retireValid, excValid, redirectValid, irqTaken}, 0);

    // R1/R2/R8: fill, out-of-order completion, in-order retirement
    base = retN; sBase = storeN;
    for (int i = 0; i < 8; i++) allocOne(100 + i, 0, (i == 3 || i == 5), t[i]);
    check("R1 full stalls", allocReady, 0);
    allocOne(200, 0, 0, x);
    cpl(t[2], 0, 0, 0);
    check("R2 head not done waits", retireValid, 0);
    cpl(t[0], 0, 0, 0);
    check("R2 head retires", {retireValid, 16'(retirePc)}, {1'b1, 16'd100});
    cpl(t[1], 0, 0, 0);
    for (int i = 3; i < 8; i++) cpl(t[i], 0, 0, 0);
    idle(10);
    check("R1 dropped alloc never retires", retN - base, 8);
    for (int i = 0; i < 8; i++) check("R2 order", retLog[base + i], 100 + i);
    check("R8 store count", storeN - sBase, 2);

    // R3: early mispredict recovery
    base = retN; rBase = redirN;
    allocOne(300, 1, 0, a0); allocOne(301, 0, 0, a1); allocOne(302, 1, 0, a2);
    allocOne(303, 0, 0, a3); allocOne(304, 0, 0, x);
    cpl(a2, 0, 1, 400);
    check("R3 redirect count", redirN - rBase, 1);
    check("R3 redirect target", lastRedir, 400);
    allocOne(400, 0, 0, x);
    check("R3 slot after branch reused", x, a3);
    cpl(x, 0, 0, 0);
    allocOne(401, 0, 0, x);
    cpl(x, 0, 0, 0);
    cpl(a0, 0, 0, 0); cpl(a1, 0, 0, 0);
    idle(8);
    check("R3 retire count", retN - base, 5);
    check("R3 retire 3", retLog[base + 2], 302);
    check("R3 retire 4", retLog[base + 3], 400);
    check("R3 retire 5", retLog[base + 4], 401);

    // R4: older mispredict overrides younger recovery
    base = retN;
    allocOne(500, 1, 0, b0); allocOne(501, 0, 0, b1); allocOne(502, 1, 0, b2);
    allocOne(503, 0, 0, x);
    cpl(b2, 0, 1, 600);
    allocOne(600, 0, 0, c0); allocOne(601, 0, 0, c1);
    cpl(c0, 0, 0, 0); cpl(c1, 0, 0, 0);
    cpl(b0, 0, 1, 700);
    check("R4 redirect target", lastRedir, 700);
    allocOne(700, 0, 0, d0);
    check("R4 tag after older branch", d0, b1);
    cpl(d0, 0, 0, 0);
    idle(8);
    check("R4 retire count", retN - base, 2);
    check("R4 retire 1", retLog[base], 500);
    check("R4 retire 2", retLog[base + 1], 700);

    // R5/R8: deferred fault; retired store survives the flush
    base = retN; sBase = storeN; eBase = excN;
    allocOne(800, 0, 1, e0); allocOne(801, 0, 0, e1); allocOne(802, 0, 0, e2);
    cpl(e1, 1, 0, 0);
    idle(3);
    check("R5 no exception at completion", excN - eBase, 0);
    check("R5 nothing retired yet", retN - base, 0);
    cpl(e0, 0, 0, 0);
    idle(4);
    check("R5 exception taken", excN - eBase, 1);
    check("R5 exception pc", lastExc, 801);
    check("R5 only older retired", retN - base, 1);
    check("R8 store before flush kept", storeN - sBase, 1);
    allocOne(900, 0, 0, x);
    cpl(x, 0, 0, 0);
    idle(4);
    check("R5 flushed entry absent", retLog[base + 1], 900);

    // R6: interrupt discards unretired work
    base = retN; sBase = storeN; iBase = irqN;
    allocOne(1000, 0, 1, g0); allocOne(1001, 0, 0, x);
    cpl(x, 0, 0, 0);
    pulseIrq();
    check("R6 irq taken", irqN - iBase, 1);
    check("R6 resume oldest", lastResume, 1000);
    check("R6 nothing retired", retN - base, 0);
    allocOne(1100, 0, 0, x);
    cpl(x, 0, 0, 0);
    idle(4);
    check("R6 discarded work absent", retLog[base], 1100);
    check("R8 discarded store not counted", storeN - sBase, 0);

    // R7: ready mispredicted branch at head retires with interrupt
    base = retN;
    allocOne(1200, 1, 0, h0); allocOne(1201, 0, 0, x);
    cpl(h0, 0, 1, 1300);
    pulseIrq();
    check("R7 branch retired", retLog[base], 1200);
    check("R7 resume at target", lastResume, 1300);
    pulseIrq();
    check("R6 empty resume", lastResume, 1300);

    // R9: exception beats interrupt
    eBase = excN; iBase = irqN;
    allocOne(1400, 0, 0, i0); allocOne(1401, 0, 0, x);
    cpl(i0, 1, 0, 0);
    pulseIrq();
    check("R9 exception wins", excN - eBase, 1);
    check("R9 exception pc", lastExc, 1400);
    check("R9 irq suppressed", irqN - iBase, 0);
    idle(2);

    // R9: interrupt beats mispredict; allocation refused that cycle
    base = retN; iBase = irqN; rBase = redirN;
    allocOne(1500, 0, 0, x); allocOne(1501, 1, 0, j1); allocOne(1502, 0, 0, x);
    irqReq = 1'b1;
    allocValid = 1'b1; allocPc = 16'd1700;
    cpl(j1, 0, 1, 1600);
    irqReq = 1'b0; allocValid = 1'b0;
    check("R9 irq taken", irqN - iBase, 1);
    check("R9 resume oldest", lastResume, 1500);
    check("R9 redirect suppressed", redirN - rBase, 0);
    allocOne(1800, 0, 0, k0);
    cpl(k0, 0, 0, 0);
    idle(4);
    check("R9 refused alloc absent", retN - base, 1);
    check("R9 next retire", retLog[base], 1800);

    summary();
  end
endmodule